// File: doc/BRIEF.md
# Add/Subtract Micro-Op Decoder

This block turns one fixed-point add or subtract instruction into a single micro-op for a three-input adder. The instruction is either a plain 32-bit word or a 64-bit prefixed add-immediate, which arrives as a prefix word plus a suffix word. The decoder is purely combinational. Its output says which register the result goes to and whether the carry pair and condition field 0 are written as well. It also names up to three operand sources (a general register, the carry register pair, or constant zero) and gives a sign-extended immediate, an output-width mode and four adder control flags.

There is one micro-op shape for every variant. Subtract, extended, minus-one and zero-addend forms differ only in how the sources are steered, in the chosen immediate, and in the invert/carry-in flags. The adder computes `(invSrc0 ? ~S0 : S0) + S1' + S2 + imm + cin`. Here `cin` is the carry register when `src1IsCarryIn` is set and 0 otherwise, XORed with `invCarryIn`. When `src1IsCarryIn` is set, S1 is used only as the carry-in. The following forms are rejected with `uopValid` low: forms with the overflow-enable bit set, unknown opcodes or extended opcodes, and bad prefixes. When `uopValid` is low, every other output is zero.

Top module: `addsub_uop_decoder`

## Requirements
- R1: With `prefixValid`=1, a prefix with bits[31:26]=1 and bits[25:24]=2, a suffix with bits[31:26]=14 and prefix bit 20 clear: the immediate is the sign extension of {prefix[17:0], suffix[15:0]} (34 bits). The destination is suffix bits[25:21]. Source 0 is the GPR in suffix bits[20:16], or constant zero when that field is 0. Sources 1 and 2 are zero. All flags are clear, and neither the carry pair nor field 0 is written.
- R2: In the form of R1 with prefix bit 20 set and RA=0, sources 0, 1 and 2 are constant zero and `addPc`=1. With prefix bit 20 set and RA≠0, the output is invalid.
- R3: Unprefixed immediate adds: opcode 14 has imm = sext(SI) and opcode 15 has imm = sext(SI)<<16. For both, an RA of 0 selects constant zero. Opcodes 12 and 13 always read GPR RA, use imm = sext(SI) and write the carry pair. SI is bits[15:0]. Source 1 is zero and no flag is set.
- R4: Opcode 8 (subtract-from immediate) gives source 0 = GPR RA, source 1 = zero, imm = sext(SI), invSrc0=1 and invCarryIn=1, and writes the carry pair.
- R5: Opcode 31 with XO (bits[9:1]) 266/10/40/8 gives sources [RA, RB, zero] and imm 0. XO 40 and 8 set invSrc0 and invCarryIn. XO 10 and 8 write the carry pair.
- R6: XO 138 and 136 give sources [RA, carry, RB] with src1IsCarryIn=1 and write the carry pair. XO 136 also sets invSrc0.
- R7: XO 234/232 (imm = all ones) and 202/200 (imm 0) give sources [RA, carry, zero] with src1IsCarryIn=1 and write the carry pair. XO 232 and 200 set invSrc0.
- R8: XO 104 gives sources [RA, zero, zero], sets invSrc0 and invCarryIn, and does not write the carry pair.
- R9: Field 0 is written exactly when bit 0 is set on a valid opcode-31 form, or when the opcode is 13. It is never written for other forms.
- R10: Opcode 31 with OE (bit 10) set, an unlisted XO, or an unlisted opcode gives `uopValid`=0, and all other outputs are 0.
- R11: `outMode` is 0 (full 64-bit result) for every valid micro-op.
- R12: With `prefixValid`=1, a prefix that fails the R1 opcode/type check, or a suffix opcode other than 14, gives an invalid output.
- R13: Source kinds are encoded as 0 = constant zero, 1 = GPR, 2 = carry pair. A source index port is 0 whenever its kind is not GPR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| prefixValid | input | 1 | prefixWord holds a prefix and insnWord is its suffix |
| prefixWord | input | 32 | Prefix word |
| insnWord | input | 32 | Instruction word or suffix |
| uopValid | output | 1 | Instruction recognised |
| destGpr | output | 5 | Target GPR index |
| destCarry | output | 1 | Carry pair is written |
| destCr0 | output | 1 | Condition field 0 is written |
| src0Kind | output | 2 | Source 0 kind |
| src0Gpr | output | 5 | Source 0 GPR index |
| src1Kind | output | 2 | Source 1 kind |
| src1Gpr | output | 5 | Source 1 GPR index |
| src2Kind | output | 2 | Source 2 kind |
| src2Gpr | output | 5 | Source 2 GPR index |
| immValue | output | DATA_W | Sign-extended immediate |
| outMode | output | 2 | Output-width mode |
| invSrc0 | output | 1 | Invert source 0 |
| src1IsCarryIn | output | 1 | Source 1 feeds the carry-in |
| invCarryIn | output | 1 | Invert carry-in |
| addPc | output | 1 | Add program counter |

## Verification
The embedded checks assume that `prefixValid` and the two words are stable and fully known whenever they are evaluated. They also assume that a prefixed form never has a condition-field write. The stimulus drives every input as a fixed 0/1 pattern while the clock is low and holds it through the sample. It builds prefixed stimuli only from the suffix opcode and leaves bit 0 of the suffix random. The random mix covers listed and unlisted extended opcodes, a set overflow-enable bit, corrupted prefixes, and RA=0 on every RA-reading form.

// File: rtl/addsub_uop_pkg.sv
package addsub_uop_pkg;
  localparam int INSN_W    = 32;
  localparam int GPR_IDX_W = 5;
  localparam int SI_W      = 16;
  localparam int PFX_IMM_W = 18;
  localparam int XO_W      = 9;

  localparam logic [5:0] OPC_PREFIX  = 6'd1;
  localparam logic [1:0] PFX_TYPE_LS = 2'd2;
  localparam logic [5:0] OPC_SUBFIMM = 6'd8;
  localparam logic [5:0] OPC_ADDIC   = 6'd12;
  localparam logic [5:0] OPC_ADDICR  = 6'd13;
  localparam logic [5:0] OPC_ADDI    = 6'd14;
  localparam logic [5:0] OPC_ADDIS   = 6'd15;
  localparam logic [5:0] OPC_XFORM   = 6'd31;

  typedef enum logic [1:0] {SRC_ZERO = 2'd0, SRC_GPR = 2'd1, SRC_CARRY = 2'd2} srcKindE;
  typedef enum logic [1:0] {OUT_FULL64 = 2'd0, OUT_RSVD = 2'd3} outModeE;
  typedef enum logic [2:0] {
    IMM_NONE = 3'd0, IMM_SI16 = 3'd1, IMM_SI16_HI = 3'd2, IMM_PREFIXED = 3'd3, IMM_ALLONES = 3'd4
  } immKindE;

  typedef struct packed {
    logic    valid;
    logic    src0FromRa;
    logic    raZeroIsConst;
    srcKindE src1Kind;
    srcKindE src2Kind;
    immKindE immKind;
    logic    writeCarry;
    logic    writeCr0;
    logic    invSrc0;
    logic    src1CarryIn;
    logic    invCarryIn;
    logic    addPc;
  } ctrlStrobesT;
endpackage

// File: rtl/addsub_uop_ctrl.sv
module addsub_uop_ctrl
  import addsub_uop_pkg::*;
(
  input  logic              prefixValid,
  input  logic [INSN_W-1:0] prefixWord,
  input  logic [INSN_W-1:0] insnWord,
  output ctrlStrobesT       strobes
);
  logic [5:0]           primOpc;
  logic [XO_W-1:0]      xoField;
  logic                 oeBit;
  logic                 rcBit;
  logic [GPR_IDX_W-1:0] raField;
  logic                 prefixOk;
  logic                 pcRelBit;

  assign primOpc  = insnWord[31:26];
  assign xoField  = insnWord[9:1];
  assign oeBit    = insnWord[10];
  assign rcBit    = insnWord[0];
  assign raField  = insnWord[20:16];
  assign prefixOk = (prefixWord[31:26] == OPC_PREFIX) && (prefixWord[25:24] == PFX_TYPE_LS)
                    && (primOpc == OPC_ADDI);
  assign pcRelBit = prefixWord[20];

  always_comb begin
    strobes = '0;
    if (prefixValid) begin
      if (prefixOk) begin
        strobes.immKind = IMM_PREFIXED;
        if (pcRelBit) begin
          strobes.valid = (raField == '0);
          strobes.addPc = (raField == '0);
        end else begin
          strobes.valid         = 1'b1;
          strobes.src0FromRa    = 1'b1;
          strobes.raZeroIsConst = 1'b1;
        end
      end
    end else begin
      unique case (primOpc)
        OPC_ADDI, OPC_ADDIS: begin
          strobes.valid         = 1'b1;
          strobes.src0FromRa    = 1'b1;
          strobes.raZeroIsConst = 1'b1;
          strobes.immKind       = (primOpc == OPC_ADDIS) ? IMM_SI16_HI : IMM_SI16;
        end
        OPC_ADDIC, OPC_ADDICR: begin
          strobes.valid      = 1'b1;
          strobes.src0FromRa = 1'b1;
          strobes.immKind    = IMM_SI16;
          strobes.writeCarry = 1'b1;
          strobes.writeCr0   = (primOpc == OPC_ADDICR);
        end
        OPC_SUBFIMM: begin
          strobes.valid      = 1'b1;
          strobes.src0FromRa = 1'b1;
          strobes.immKind    = IMM_SI16;
          strobes.writeCarry = 1'b1;
          strobes.invSrc0    = 1'b1;
          strobes.invCarryIn = 1'b1;
        end
        OPC_XFORM: begin
          if (!oeBit) begin
            strobes.src0FromRa = 1'b1;
            strobes.valid      = 1'b1;
            unique case (xoField)
              9'd266: strobes.src1Kind = SRC_GPR;
              9'd10: begin
                strobes.src1Kind   = SRC_GPR;
                strobes.writeCarry = 1'b1;
              end
              9'd40: begin
                strobes.src1Kind   = SRC_GPR;
                strobes.invSrc0    = 1'b1;
                strobes.invCarryIn = 1'b1;
              end
              9'd8: begin
                strobes.src1Kind   = SRC_GPR;
                strobes.invSrc0    = 1'b1;
                strobes.invCarryIn = 1'b1;
                strobes.writeCarry = 1'b1;
              end
              9'd138, 9'd136: begin
                strobes.src1Kind    = SRC_CARRY;
                strobes.src2Kind    = SRC_GPR;
                strobes.src1CarryIn = 1'b1;
                strobes.writeCarry  = 1'b1;
                strobes.invSrc0     = (xoField == 9'd136);
              end
              9'd234, 9'd232, 9'd202, 9'd200: begin
                strobes.src1Kind    = SRC_CARRY;
                strobes.src1CarryIn = 1'b1;
                strobes.writeCarry  = 1'b1;
                strobes.immKind     = xoField[5] ? IMM_ALLONES : IMM_NONE;
                strobes.invSrc0     = !xoField[1];
              end
              9'd104: begin
                strobes.invSrc0    = 1'b1;
                strobes.invCarryIn = 1'b1;
              end
              default: strobes = '0;
            endcase
            strobes.writeCr0 = strobes.valid & rcBit;
          end
        end
        default: strobes = '0;
      endcase
    end
  end
endmodule

// File: rtl/addsub_uop_dpath.sv
module addsub_uop_dpath
  import addsub_uop_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  ctrlStrobesT          strobes,
  input  logic [INSN_W-1:0]    prefixWord,
  input  logic [INSN_W-1:0]    insnWord,
  output logic [GPR_IDX_W-1:0] destGpr,
  output logic                 destCarry,
  output logic                 destCr0,
  output srcKindE              src0Kind,
  output logic [GPR_IDX_W-1:0] src0Gpr,
  output srcKindE              src1Kind,
  output logic [GPR_IDX_W-1:0] src1Gpr,
  output srcKindE              src2Kind,
  output logic [GPR_IDX_W-1:0] src2Gpr,
  output logic [DATA_W-1:0]    immValue,
  output outModeE              outMode,
  output logic [3:0]           flagBits
);
  localparam int PIMM_W = PFX_IMM_W + SI_W;

  logic [GPR_IDX_W-1:0] rtField, raField, rbField;
  logic [SI_W-1:0]      siField;
  logic [PIMM_W-1:0]    prefImm;

  assign rtField = insnWord[25:21];
  assign raField = insnWord[20:16];
  assign rbField = insnWord[15:11];
  assign siField = insnWord[SI_W-1:0];
  assign prefImm = {prefixWord[PFX_IMM_W-1:0], siField};

  always_comb begin
    unique case (strobes.immKind)
      IMM_SI16:     immValue = {{(DATA_W-SI_W){siField[SI_W-1]}}, siField};
      IMM_SI16_HI:  immValue = {{(DATA_W-2*SI_W){siField[SI_W-1]}}, siField, {SI_W{1'b0}}};
      IMM_PREFIXED: immValue = {{(DATA_W-PIMM_W){prefImm[PIMM_W-1]}}, prefImm};
      IMM_ALLONES:  immValue = '1;
      default:      immValue = '0;
    endcase
    if (!strobes.valid) immValue = '0;
  end

  always_comb begin
    src0Kind = SRC_ZERO;
    src0Gpr  = '0;
    if (strobes.valid && strobes.src0FromRa &&
        !(strobes.raZeroIsConst && raField == '0)) begin
      src0Kind = SRC_GPR;
      src0Gpr  = raField;
    end
  end

  always_comb begin
    src1Kind = strobes.valid ? strobes.src1Kind : SRC_ZERO;
    src2Kind = strobes.valid ? strobes.src2Kind : SRC_ZERO;
    src1Gpr  = (src1Kind == SRC_GPR) ? rbField : '0;
    src2Gpr  = (src2Kind == SRC_GPR) ? rbField : '0;
  end

  assign destGpr   = strobes.valid ? rtField : '0;
  assign destCarry = strobes.valid & strobes.writeCarry;
  assign destCr0   = strobes.valid & strobes.writeCr0;
  assign outMode   = OUT_FULL64;
  assign flagBits  = strobes.valid ?
                     {strobes.invSrc0, strobes.src1CarryIn, strobes.invCarryIn, strobes.addPc} : 4'b0;
endmodule

// File: rtl/addsub_uop_decoder.sv
module addsub_uop_decoder
  import addsub_uop_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              prefixValid,
  input  logic [31:0]       prefixWord,
  input  logic [31:0]       insnWord,
  output logic              uopValid,
  output logic [4:0]        destGpr,
  output logic              destCarry,
  output logic              destCr0,
  output logic [1:0]        src0Kind,
  output logic [4:0]        src0Gpr,
  output logic [1:0]        src1Kind,
  output logic [4:0]        src1Gpr,
  output logic [1:0]        src2Kind,
  output logic [4:0]        src2Gpr,
  output logic [DATA_W-1:0] immValue,
  output logic [1:0]        outMode,
  output logic              invSrc0,
  output logic              src1IsCarryIn,
  output logic              invCarryIn,
  output logic              addPc
);
  ctrlStrobesT strobes;
  srcKindE     k0, k1, k2;
  outModeE     modeE;
  logic [3:0]  flagBits;

  addsub_uop_ctrl ctrl_i (
    .prefixValid(prefixValid), .prefixWord(prefixWord), .insnWord(insnWord), .strobes(strobes)
  );

  addsub_uop_dpath #(.DATA_W(DATA_W)) dpath_i (
    .strobes(strobes), .prefixWord(prefixWord), .insnWord(insnWord),
    .destGpr(destGpr), .destCarry(destCarry), .destCr0(destCr0),
    .src0Kind(k0), .src0Gpr(src0Gpr), .src1Kind(k1), .src1Gpr(src1Gpr),
    .src2Kind(k2), .src2Gpr(src2Gpr), .immValue(immValue), .outMode(modeE),
    .flagBits(flagBits)
  );

  assign uopValid      = strobes.valid;
  assign src0Kind      = k0;
  assign src1Kind      = k1;
  assign src2Kind      = k2;
  assign outMode       = modeE;
  assign invSrc0       = flagBits[3];
  assign src1IsCarryIn = flagBits[2];
  assign invCarryIn    = flagBits[1];
  assign addPc         = flagBits[0];

  always_comb begin
    a_r10_invalid_quiet: assert (uopValid || (immValue == '0 && k0 == SRC_ZERO &&
                                 k1 == SRC_ZERO && k2 == SRC_ZERO && !destCarry))
      else $error("invalid micro-op leaks operand fields");
    a_r6_carry_slot: assert (!src1IsCarryIn || k1 == SRC_CARRY)
      else $error("carry-in flag without carry source in slot 1");
    a_r2_pc_zero_base: assert (!addPc || (k0 == SRC_ZERO && prefixValid))
      else $error("add-PC with non-zero base");
    a_r13_unused_index: assert ((k0 == SRC_GPR || src0Gpr == '0) &&
                                (k1 == SRC_GPR || src1Gpr == '0) &&
                                (k2 == SRC_GPR || src2Gpr == '0))
      else $error("index set on non-GPR source");
    a_r9_no_cr0_prefixed: assert (!(prefixValid && destCr0))
      else $error("field 0 written by prefixed form");
    a_r8_inv_pair: assert (!invCarryIn || invSrc0)
      else $error("carry-in inverted without source inversion");
  end
endmodule

// File: tb/addsub_uop_decoder_tb_top.sv
module addsub_uop_decoder_tb_top;
  localparam int DATA_W = 64;
  localparam int EXP_W  = 35 + DATA_W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              prefixValid = 1'b0;
  logic [31:0]       prefixWord = '0, insnWord = '0;
  logic              uopValid, destCarry, destCr0, invSrc0, src1IsCarryIn, invCarryIn, addPc;
  logic [4:0]        destGpr, src0Gpr, src1Gpr, src2Gpr;
  logic [1:0]        src0Kind, src1Kind, src2Kind, outMode;
  logic [DATA_W-1:0] immValue;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  addsub_uop_decoder #(.DATA_W(DATA_W)) dut_i (
    .prefixValid(prefixValid), .prefixWord(prefixWord), .insnWord(insnWord),
    .uopValid(uopValid), .destGpr(destGpr), .destCarry(destCarry), .destCr0(destCr0),
    .src0Kind(src0Kind), .src0Gpr(src0Gpr), .src1Kind(src1Kind), .src1Gpr(src1Gpr),
    .src2Kind(src2Kind), .src2Gpr(src2Gpr), .immValue(immValue), .outMode(outMode),
    .invSrc0(invSrc0), .src1IsCarryIn(src1IsCarryIn), .invCarryIn(invCarryIn), .addPc(addPc)
  );

  function automatic logic [DATA_W-1:0] sx(input logic [63:0] v, input int w);
    logic [63:0] r;
    r = v << (64 - w);
    r = $signed(r) >>> (64 - w);
    return r[DATA_W-1:0];
  endfunction

  // Reference model built from the requirement list (kinds: 0 zero, 1 GPR, 2 carry).
  task automatic model(input logic pv, input logic [31:0] pw, input logic [31:0] iw,
                       output logic [EXP_W-1:0] e, output string tag);
    logic v = 0, dc = 0, dcr = 0, f0 = 0, f1 = 0, f2 = 0, f3 = 0;
    logic [1:0] k0 = 0, k1 = 0, k2 = 0;
    logic [4:0] g0 = 0, g1 = 0, g2 = 0;
    logic [DATA_W-1:0] im = '0;
    logic [5:0] op = iw[31:26];
    logic [4:0] rt = iw[25:21], ra = iw[20:16], rb = iw[15:11];
    logic [8:0] xo = iw[9:1];
    logic [DATA_W-1:0] si = sx({48'b0, iw[15:0]}, 16);
    tag = "R10";
    if (pv) begin
      tag = "R12";
      if (pw[31:26] == 6'd1 && pw[25:24] == 2'd2 && op == 6'd14) begin
        im = sx({30'b0, pw[17:0], iw[15:0]}, 34);
        if (pw[20]) begin
          tag = "R2";
          if (ra == 0) begin v = 1; f0 = 1; end
        end else begin
          tag = "R1"; v = 1;
          if (ra != 0) begin k0 = 1; g0 = ra; end
        end
      end
    end else begin
      case (op)
        6'd14, 6'd15: begin
          tag = "R3"; v = 1;
          im = (op == 6'd15) ? (si << 16) : si;
          if (ra != 0) begin k0 = 1; g0 = ra; end
        end
        6'd12, 6'd13: begin
          tag = (op == 6'd13) ? "R3 R9" : "R3"; v = 1; dc = 1; dcr = (op == 6'd13);
          im = si; k0 = 1; g0 = ra;
        end
        6'd8: begin tag = "R4"; v = 1; dc = 1; im = si; k0 = 1; g0 = ra; f3 = 1; f1 = 1; end
        6'd31: if (!iw[10]) begin
          k0 = 1; g0 = ra; v = 1;
          case (xo)
            9'd266, 9'd10, 9'd40, 9'd8: begin
              tag = "R5"; k1 = 1; g1 = rb;
              if (xo == 9'd40 || xo == 9'd8) begin f3 = 1; f1 = 1; end
              dc = (xo == 9'd10 || xo == 9'd8);
            end
            9'd138, 9'd136: begin
              tag = "R6"; k1 = 2; k2 = 1; g2 = rb; f2 = 1; dc = 1; f3 = (xo == 9'd136);
            end
            9'd234, 9'd232, 9'd202, 9'd200: begin
              tag = "R7"; k1 = 2; f2 = 1; dc = 1;
              im = (xo == 9'd234 || xo == 9'd232) ? '1 : '0;
              f3 = (xo == 9'd232 || xo == 9'd200);
            end
            9'd104: begin tag = "R8"; f3 = 1; f1 = 1; end
            default: v = 0;
          endcase
          if (v) dcr = iw[0];
        end
        default: v = 0;
      endcase
    end
    if (v) e = {1'b1, rt, dc, dcr, k0, g0, k1, g1, k2, g2, im, 2'b00, f3, f2, f1, f0};
    else   e = '0;
  endtask

  task automatic apply(input logic pv, input logic [31:0] pw, input logic [31:0] iw, input string note);
    logic [EXP_W-1:0] exp, act;
    string tag;
    @(negedge clk);
    prefixValid = pv; prefixWord = pw; insnWord = iw;
    model(pv, pw, iw, exp, tag);
    #2;
    act = {uopValid, destGpr, destCarry, destCr0, src0Kind, src0Gpr, src1Kind, src1Gpr,
           src2Kind, src2Gpr, immValue, outMode, invSrc0, src1IsCarryIn, invCarryIn, addPc};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s R11 R13 %s pfx=%h insn=%h actual=%h expected=%h",
               tag, note, pw, iw, act, exp);
    end
  endtask

  localparam int XO_N = 11;
  int xoList[XO_N] = '{266, 10, 40, 8, 138, 136, 234, 232, 202, 200, 104};

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R10 reset-like state: all-zero inputs decode as invalid
    apply(0, 32'h0, 32'h0, "R10 zero word");
    // Directed vectors
    apply(1, 32'h06012345, 32'h38646789, "R1 paddi");
    apply(1, 32'h06112345, 32'h38606789, "R2 pc-relative");
    apply(1, 32'h06112345, 32'h38646789, "R2 pc-rel RA!=0");
    apply(1, 32'h0603FFFF, 32'h38608000, "R1 negative imm");
    apply(1, 32'h07012345, 32'h38646789, "R12 bad type");
    apply(1, 32'h06012345, 32'h3C646789, "R12 bad suffix");
    apply(0, 32'h0, 32'h7c642851, "R5 R9 subf.");
    apply(0, 32'h0, 32'h20641234, "R4 subfic");
    apply(0, 32'h0, 32'h7c642811, "R5 subfc.");
    apply(0, 32'h0, 32'h7c642915, "R6 adde.");
    apply(0, 32'h0, 32'h7c642911, "R6 subfe.");
    apply(0, 32'h0, 32'h7c6401d5, "R7 addme.");
    apply(0, 32'h0, 32'h7c6401d1, "R7 subfme.");
    apply(0, 32'h0, 32'h7c640195, "R7 addze.");
    apply(0, 32'h0, 32'h7c640191, "R7 subfze.");
    apply(0, 32'h0, 32'h7c6400d1, "R8 neg.");
    apply(0, 32'h0, 32'h7c642e14, "R10 add with OE");
    apply(0, 32'h0, 32'h3C60FFFF, "R3 addis RA=0");
    apply(0, 32'h0, 32'h30608000, "R3 addic RA=0 reads GPR");
    apply(0, 32'h0, 32'h34641234, "R3 R9 addic.");
    // Constrained random mix
    for (int n = 0; n < 4000; n++) begin
      int sel = $urandom % 20;
      logic [31:0] w = $urandom;
      logic [31:0] p = $urandom;
      if ($urandom % 4 == 0) w[20:16] = 5'd0;
      if (sel <= 10) begin
        w[31:26] = 6'd31;
        w[9:1] = xoList[sel][8:0];
        w[10] = ($urandom % 8 == 0);
        apply(0, 32'h0, w, "rand xform");
      end else if (sel <= 15) begin
        case (sel)
          11: w[31:26] = 6'd14;
          12: w[31:26] = 6'd15;
          13: w[31:26] = 6'd12;
          14: w[31:26] = 6'd13;
          default: w[31:26] = 6'd8;
        endcase
        apply(0, 32'h0, w, "rand dform");
      end else if (sel == 16) begin
        p[31:24] = 8'h06;
        w[31:26] = 6'd14;
        apply(1, p, w, "rand prefixed");
      end else if (sel == 17) begin
        if ($urandom % 2 == 0) begin p[31:24] = 8'h06; end
        w[31:26] = ($urandom % 2 == 0) ? 6'd14 : w[31:26];
        apply(1, p, w, "rand bad prefix");
      end else if (sel == 18) begin
        apply(0, 32'h0, w, "rand word");
      end else begin
        w[31:26] = 6'd31;
        apply(0, 32'h0, w, "rand xo");
      end
    end
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule